// File: doc/BRIEF.md
# Variable-Page Associative Translation Buffer

This block is a fully associative address translation buffer with 64 entries by default. Each entry stores a virtual page number, an 8-bit address-space identifier, a physical page number and a 9-bit flag word. The flag word sets the entry's page size, its valid state and whether it is shared across address spaces. A lookup strobe presents a 32-bit virtual address, the current address-space identifier and a switch that turns the identifier compare on or off. Every entry is compared in parallel. One clock cycle later the block reports one of three outcomes. A single hit returns the entry index and the translated physical address. A miss and a multi-hit each raise their own flag.

Entries are loaded from two staging words. The word `stage_hi` supplies the page number and the identifier. The word `stage_lo` supplies the physical page and the flags. The write goes to the slot named by a replacement pointer. That pointer advances on every lookup and wraps either at a programmable boundary or at the end of the array. Software can set the pointer and the boundary together with one configuration write. A single invalidate strobe drops every entry at once.

Top module: `tlb_assoc`

## Requirements
- R1: Flag bits 7 and 4 choose the page size. {bit7,bit4} = 00 gives 1 KB and compares vaddr[31:10]. 01 gives 4 KB and compares [31:12]. 10 gives 64 KB and compares [31:16]. 11 gives 1 MB and compares [31:20].
- R2: An entry hits when three conditions hold. Its valid flag (bit 8) is set. The virtual address equals the stored page number in every compared bit. Either the shared flag (bit 1) is set or the stored identifier equals `lkp_asid`.
- R3: When `asid_en` is 0, the identifier and shared-flag condition is left out of the match.
- R4: No hit sets `res_miss`. Two or more hits set `res_multi` instead of `res_hit`. In both cases `res_idx` and `res_paddr` read 0.
- R5: On a hit, `res_paddr` takes the physical page bits under the entry's compare mask and the virtual address bits outside that mask.
- R6: The result outputs are registered. `res_valid` is high for exactly the one cycle after the cycle in which `lkp_req` was high.
- R7: Each lookup moves `rep_ptr` to `rep_ptr`+1. If that value equals the programmed boundary, or equals the entry count, the pointer goes to 0 instead. A boundary of 0 therefore means the pointer wraps only at the end of the array.
- R8: `ld_req` writes the slot named by `rep_ptr` with the following fields. The page number comes from stage_hi[31:10]. The identifier comes from stage_hi[7:0]. The physical page comes from stage_lo[28:10]. The flags come from stage_lo[8:0]. A load does not move `rep_ptr`.
- R9: `inval_all` clears the valid flag of every entry. If a load arrives in the same cycle, the invalidate takes priority and the loaded entry is not valid.
- R10: After reset, every entry is invalid and both the pointer and the boundary are 0.
- R11: `cfg_wr` sets the pointer to `cfg_ptr` and the boundary to `cfg_bnd`. It takes priority over a lookup in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_req | input | 1 | Lookup strobe |
| lkp_vaddr | input | 32 | Virtual address to translate |
| lkp_asid | input | 8 | Current address-space identifier |
| asid_en | input | 1 | 1 = apply the identifier/shared condition |
| ld_req | input | 1 | Load one entry from the staging words |
| stage_hi | input | 32 | Staging word: page number and identifier |
| stage_lo | input | 32 | Staging word: physical page and flags |
| inval_all | input | 1 | Clear every valid flag |
| cfg_wr | input | 1 | Write replacement pointer and boundary |
| cfg_ptr | input | 6 | New replacement pointer |
| cfg_bnd | input | 6 | New wrap boundary |
| rep_ptr | output | 6 | Current replacement pointer |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | Exactly one entry matched |
| res_miss | output | 1 | No entry matched |
| res_multi | output | 1 | More than one entry matched |
| res_idx | output | 6 | Index of the matching entry |
| res_paddr | output | 32 | Translated physical address |

## Verification
Corruption in the stored entries or in the match logic does not show until a later lookup. That lookup then reports the wrong one of hit, miss or multi-hit, or returns a physical address with bad high bits, one cycle after its strobe. A wrong compare mask only shows when the virtual address differs from the stored page number inside the page-offset bits. The stimulus therefore stores page numbers with stray low bits and also probes the next page just past a small page. A fault in the pointer shows at `rep_ptr` on the cycle after a lookup. It also shows as a loaded entry appearing at the wrong index.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_LO = 10;
  localparam int VPN_W  = VA_W - OFF_LO;
  localparam int PPN_W  = 19;
  localparam int ASID_W = 8;
  localparam int FLG_W  = 9;
  localparam int F_VALID  = 8;
  localparam int F_SZ_HI  = 7;
  localparam int F_SZ_LO  = 4;
  localparam int F_SHARED = 1;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic [FLG_W-1:0]  flags;
  } tlb_ent_t;

  function automatic logic [VPN_W-1:0] page_mask(input logic [FLG_W-1:0] f);
    logic [VPN_W-1:0] m;
    case ({f[F_SZ_HI], f[F_SZ_LO]})
      2'b00:   m = {VPN_W{1'b1}};
      2'b01:   m = {{(VPN_W-2){1'b1}}, 2'b00};
      2'b10:   m = {{(VPN_W-6){1'b1}}, 6'b0};
      default: m = {{(VPN_W-10){1'b1}}, 10'b0};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int N_ENT = 64,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_ent_t         wr_ent,
  input  logic             inval,
  output tlb_ent_t         ents [N_ENT],
  output logic [N_ENT-1:0] valid_q
);
  tlb_ent_t mem [N_ENT];

  // entry contents carry no reset; only the valid vector does
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (rst || inval) valid_q <= '0;
    else if (wr_en)   valid_q[wr_idx] <= wr_ent.flags[F_VALID];
  end

  assign ents = mem;

  // R9
  inval_clr_chk: assert property (@(posedge clk) disable iff (rst)
    inval |=> (valid_q == '0));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N_ENT = 64
) (
  input  tlb_ent_t          ents [N_ENT],
  input  logic [N_ENT-1:0]  valid_q,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  input  logic              asid_en,
  output logic [N_ENT-1:0]  hit_vec
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    logic [VPN_W-1:0] msk;
    logic             pg_eq;
    logic             id_ok;
    assign msk   = page_mask(ents[g].flags);
    assign pg_eq = (((va[VA_W-1:OFF_LO] ^ ents[g].vpn) & msk) == '0);
    assign id_ok = !asid_en || ents[g].flags[F_SHARED] || (ents[g].asid == asid);
    assign hit_vec[g] = valid_q[g] && pg_eq && id_ok;
  end
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_pkg::*;
#(
  parameter int N_ENT = 64,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [VA_W-1:0]  va,
  input  logic [N_ENT-1:0] hit_vec,
  input  tlb_ent_t         ents [N_ENT],
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_miss,
  output logic             res_multi,
  output logic [IDX_W-1:0] res_idx,
  output logic [VA_W-1:0]  res_paddr
);
  logic             any_c, multi_c;
  logic [IDX_W-1:0] idx_c;
  logic [VA_W-1:0]  mask32, ppn32, pa_c;

  always_comb begin
    any_c   = 1'b0;
    multi_c = 1'b0;
    idx_c   = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (hit_vec[i]) begin
        if (any_c) multi_c = 1'b1;
        any_c = 1'b1;
        idx_c = IDX_W'(i);
      end
    end
  end

  assign mask32 = {page_mask(ents[idx_c].flags), {OFF_LO{1'b0}}};
  assign ppn32  = VA_W'({ents[idx_c].ppn, {OFF_LO{1'b0}}});
  assign pa_c   = (ppn32 & mask32) | (va & ~mask32);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_multi <= 1'b0;
      res_idx   <= '0;
      res_paddr <= '0;
    end else begin
      res_valid <= req;
      res_hit   <= req && any_c && !multi_c;
      res_miss  <= req && !any_c;
      res_multi <= req && multi_c;
      res_idx   <= (req && any_c && !multi_c) ? idx_c : '0;
      res_paddr <= (req && any_c && !multi_c) ? pa_c : '0;
    end
  end

  // R6
  res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(req));
  // R4
  res_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({res_hit, res_miss, res_multi}) == (res_valid ? 1 : 0));
  // R5
  off_pass_chk: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (res_paddr[OFF_LO-1:0] == $past(va[OFF_LO-1:0])));
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
  parameter int N_ENT = 64,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_ptr,
  input  logic [IDX_W-1:0] cfg_bnd,
  output logic [IDX_W-1:0] ptr
);
  logic [IDX_W-1:0] bnd;
  logic [IDX_W:0]   nxt;

  assign nxt = {1'b0, ptr} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      bnd <= '0;
    end else if (cfg_wr) begin
      ptr <= cfg_ptr;
      bnd <= cfg_bnd;
    end else if (step) begin
      if (nxt == {1'b0, bnd} || nxt == (IDX_W+1)'(N_ENT)) ptr <= '0;
      else ptr <= nxt[IDX_W-1:0];
    end
  end

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !cfg_wr) |=> (ptr == '0 || ptr == $past(ptr) + 1'b1));
  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !cfg_wr) |=> $stable(ptr));
  // R11
  ptr_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (ptr == $past(cfg_ptr)));
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int N_ENT = 64,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lkp_req,
  input  logic [31:0]       lkp_vaddr,
  input  logic [7:0]        lkp_asid,
  input  logic              asid_en,
  input  logic              ld_req,
  input  logic [31:0]       stage_hi,
  input  logic [31:0]       stage_lo,
  input  logic              inval_all,
  input  logic              cfg_wr,
  input  logic [IDX_W-1:0]  cfg_ptr,
  input  logic [IDX_W-1:0]  cfg_bnd,
  output logic [IDX_W-1:0]  rep_ptr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_multi,
  output logic [IDX_W-1:0]  res_idx,
  output logic [31:0]       res_paddr
);
  tlb_ent_t         ents [N_ENT];
  logic [N_ENT-1:0] valid_q;
  logic [N_ENT-1:0] hit_vec;
  tlb_ent_t         ld_ent;

  assign ld_ent.vpn   = stage_hi[31:OFF_LO];
  assign ld_ent.asid  = stage_hi[ASID_W-1:0];
  assign ld_ent.ppn   = stage_lo[OFF_LO+PPN_W-1:OFF_LO];
  assign ld_ent.flags = stage_lo[FLG_W-1:0];

  tlb_store #(.N_ENT(N_ENT)) u_store (
    .clk(clk), .rst(rst), .wr_en(ld_req), .wr_idx(rep_ptr), .wr_ent(ld_ent),
    .inval(inval_all), .ents(ents), .valid_q(valid_q)
  );

  tlb_match #(.N_ENT(N_ENT)) u_match (
    .ents(ents), .valid_q(valid_q), .va(lkp_vaddr), .asid(lkp_asid),
    .asid_en(asid_en), .hit_vec(hit_vec)
  );

  tlb_resolve #(.N_ENT(N_ENT)) u_resolve (
    .clk(clk), .rst(rst), .req(lkp_req), .va(lkp_vaddr), .hit_vec(hit_vec),
    .ents(ents), .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_multi(res_multi), .res_idx(res_idx), .res_paddr(res_paddr)
  );

  tlb_repl #(.N_ENT(N_ENT)) u_repl (
    .clk(clk), .rst(rst), .step(lkp_req), .cfg_wr(cfg_wr), .cfg_ptr(cfg_ptr),
    .cfg_bnd(cfg_bnd), .ptr(rep_ptr)
  );

  // R4
  idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_miss || res_multi) |-> (res_idx == '0 && res_paddr == '0));
endmodule

// File: tb/test_tlb_assoc.sv
module test_tlb_assoc;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        lkp_req, asid_en, ld_req, inval_all, cfg_wr;
  logic [31:0] lkp_vaddr, stage_hi, stage_lo;
  logic [7:0]  lkp_asid;
  logic [5:0]  cfg_ptr, cfg_bnd, rep_ptr, res_idx;
  logic        res_valid, res_hit, res_miss, res_multi;
  logic [31:0] res_paddr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_assoc i_tlb_assoc (
    .clk(clk), .rst(rst), .lkp_req(lkp_req), .lkp_vaddr(lkp_vaddr),
    .lkp_asid(lkp_asid), .asid_en(asid_en), .ld_req(ld_req),
    .stage_hi(stage_hi), .stage_lo(stage_lo), .inval_all(inval_all),
    .cfg_wr(cfg_wr), .cfg_ptr(cfg_ptr), .cfg_bnd(cfg_bnd), .rep_ptr(rep_ptr),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_multi(res_multi), .res_idx(res_idx), .res_paddr(res_paddr)
  );

  // kind: 0 hit, 1 miss, 2 multi
  localparam logic [31:0] V_VA   [NV] = '{32'h004003FF, 32'h004003FF, 32'h00400000,
    32'h10002ABC, 32'h10003000, 32'h2003BEEF, 32'h300ABCDE, 32'h30055123,
    32'h40000010, 32'h00400400};
  localparam logic [7:0]  V_ID   [NV] = '{8'h11, 8'h22, 8'h22, 8'h77, 8'h05,
    8'h05, 8'h05, 8'h05, 8'h05, 8'h11};
  localparam logic        V_EN   [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [1:0]  V_KIND [NV] = '{2'd0, 2'd1, 2'd0, 2'd0, 2'd1, 2'd0,
    2'd0, 2'd2, 2'd1, 2'd1};
  localparam logic [5:0]  V_IDX  [NV] = '{6'd0, 6'd0, 6'd0, 6'd1, 6'd0, 6'd2,
    6'd3, 6'd0, 6'd0, 6'd0};
  localparam logic [31:0] V_PA   [NV] = '{32'h012347FF, 32'h0, 32'h01234400,
    32'h00ABCABC, 32'h0, 32'h0567BEEF, 32'h1FFABCDE, 32'h0, 32'h0, 32'h0};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] id, input logic en);
    @(negedge clk);
    lkp_req = 1'b1; lkp_vaddr = va; lkp_asid = id; asid_en = en;
    @(negedge clk);
    lkp_req = 1'b0;
  endtask

  task automatic set_ptr(input logic [5:0] p, input logic [5:0] b);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ptr = p; cfg_bnd = b;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic load_at(input logic [5:0] slot, input logic [31:0] hi,
                         input logic [31:0] lo);
    set_ptr(slot, 6'd0);
    ld_req = 1'b1; stage_hi = hi; stage_lo = lo;
    @(negedge clk);
    ld_req = 1'b0;
  endtask

  task automatic expect_kind(input logic [1:0] kind, input logic [5:0] idx,
                             input logic [31:0] pa, input string tag);
    chk(res_valid, {tag, " valid"}, 32'(res_valid), 32'd1);
    chk({res_hit, res_miss, res_multi} == (kind == 2'd0 ? 3'b100 :
        kind == 2'd1 ? 3'b010 : 3'b001), {tag, " kind"},
        32'({res_hit, res_miss, res_multi}), 32'(kind));
    chk(res_idx == idx, {tag, " idx"}, 32'(res_idx), 32'(idx));
    chk(res_paddr == pa, {tag, " paddr"}, res_paddr, pa);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; lkp_req = 0; asid_en = 0; ld_req = 0; inval_all = 0; cfg_wr = 0;
    lkp_vaddr = 0; lkp_asid = 0; stage_hi = 0; stage_lo = 0; cfg_ptr = 0; cfg_bnd = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10: reset state
    chk(rep_ptr == 6'd0, "R10 ptr", 32'(rep_ptr), 0);
    chk(!res_valid, "R10 res_valid", 32'(res_valid), 0);
    lookup(32'h004003FF, 8'h11, 1'b1);
    expect_kind(2'd1, 6'd0, 32'h0, "R10 empty");
    // R6: one-cycle pulse
    @(negedge clk);
    chk(!res_valid, "R6 pulse end", 32'(res_valid), 0);
    // R10: boundary 0 means wrap only at 64; ptr advanced once
    chk(rep_ptr == 6'd1, "R7 step", 32'(rep_ptr), 1);

    // R8: loads at pointer slots
    load_at(6'd0, 32'h00400011, 32'h01234500);
    chk(rep_ptr == 6'd0, "R8 no step", 32'(rep_ptr), 0);
    load_at(6'd1, 32'h10002005, 32'h00ABC112);
    load_at(6'd2, 32'h2003F405, 32'h0567F580);
    load_at(6'd3, 32'h30000005, 32'h1FF00190);
    load_at(6'd4, 32'h30055005, 32'h00001110);
    load_at(6'd5, 32'h40000005, 32'h00002010);

    // R1 R2 R3 R4 R5: table walk
    for (int k = 0; k < NV; k++) begin
      lookup(V_VA[k], V_ID[k], V_EN[k]);
      expect_kind(V_KIND[k], V_IDX[k], V_PA[k], $sformatf("R1/R2/R3/R4/R5 vec%0d", k));
    end

    // R7: wrap at programmed boundary
    set_ptr(6'd3, 6'd5);
    lookup(32'h0, 8'h0, 1'b1);
    @(negedge clk);
    chk(rep_ptr == 6'd4, "R7 bnd step", 32'(rep_ptr), 4);
    lookup(32'h0, 8'h0, 1'b1);
    chk(rep_ptr == 6'd0, "R7 bnd wrap", 32'(rep_ptr), 0);
    // R7: wrap at entry count with boundary 0
    set_ptr(6'd62, 6'd0);
    lookup(32'h0, 8'h0, 1'b1);
    chk(rep_ptr == 6'd63, "R7 top step", 32'(rep_ptr), 63);
    lookup(32'h0, 8'h0, 1'b1);
    chk(rep_ptr == 6'd0, "R7 top wrap", 32'(rep_ptr), 0);

    // R11: cfg_wr beats same-cycle lookup
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ptr = 6'd9; cfg_bnd = 6'd0; lkp_req = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; lkp_req = 1'b0;
    chk(rep_ptr == 6'd9, "R11 cfg priority", 32'(rep_ptr), 9);

    // R8: load at slot 10, found at index 10
    load_at(6'd10, 32'h60000033, 32'h0ABCD100);
    lookup(32'h60000123, 8'h33, 1'b1);
    expect_kind(2'd0, 6'd10, 32'h0ABCD123, "R8 slot10");

    // R9: invalidate all
    @(negedge clk);
    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
    lookup(32'h004003FF, 8'h11, 1'b1);
    expect_kind(2'd1, 6'd0, 32'h0, "R9 inval");
    lookup(32'h60000123, 8'h33, 1'b1);
    expect_kind(2'd1, 6'd0, 32'h0, "R9 inval slot10");

    // R9: invalidate wins over same-cycle load
    set_ptr(6'd20, 6'd0);
    ld_req = 1'b1; inval_all = 1'b1;
    stage_hi = 32'h50000001; stage_lo = 32'h00003100;
    @(negedge clk);
    ld_req = 1'b0; inval_all = 1'b0;
    lookup(32'h50000000, 8'h01, 1'b1);
    expect_kind(2'd1, 6'd0, 32'h0, "R9 inval over load");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule